// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Host Controller

This block sits between a simple request/response port and a synchronous pipelined SRAM. The SRAM moves two words per address and transfers data on both halves of every clock. Each accepted request puts one address on the memory bus. A write supplies two words and per-lane byte enables, and the block lays them out as two half-cycle phases. A read gathers the two returned words from the phase pair and hands them back as one double-width item. The design runs on a single clock: each half-cycle is a separate phase register (phase 0 and phase 1), and an output stage outside this block serialises the pair.

The memory's one-bit burst counter starts at the low address bit and wraps inside the pair. The controller therefore puts the addressed word first on the bus, while the user side always sees data in address order. The block supports two read-return timings, chosen per request by a mode input. With the delay-locked loop running, read data starts one and a half cycles after the address. With it bypassed, read data starts one full cycle after the address. Reads complete in order, and a small tag queue records which word came first for each outstanding read.

Top module: `burst2_sram_ctrl`

## Requirements
- R1: While reset is asserted, `mem_ld_n` is 1, `mem_d_oe` is 0, every byte write select is 1 and `rsp_valid` is 0. After reset, with no request pending, `req_ready` is 1.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both 1) appears on the memory bus in the next cycle. In that cycle `mem_ld_n`=0, `mem_addr`=`req_addr`, and `mem_rw` is 1 for a read and 0 for a write. `mem_ld_n` is 1 in every cycle that carries no new access.
- R3: `req_ready` is 0 in the cycle after an acceptance. As a result `mem_ld_n` is never 0 in two consecutive cycles.
- R4: In the cycle right after a write address cycle, `mem_d_oe`=1. `mem_d_p0` carries the word at the start address and `mem_d_p1` carries the other word of the pair. Word 0 (even address) is `req_wdata[DW-1:0]` and word 1 is the upper half. `mem_d_oe` is 0 in every other cycle.
- R5: In the write data cycle, each byte write select is the inverse of the enable for that lane of the word in the same phase. `req_be[LN-1:0]` are word 0's lanes and `req_be[2*LN-1:LN]` are word 1's lanes, with lane j covering data bits 9j+8..9j. Outside write data cycles all selects are 1.
- R6: A write address appears no earlier than four cycles after the previous read address. This leaves one idle access slot for bus turnaround.
- R7: For a read issued with `dll_off`=1, the first word is taken from `mem_q_p0` and the second from `mem_q_p1` in the cycle after the address cycle. `rsp_valid` is 1 in the cycle after that.
- R8: For a read issued with `dll_off`=0, the first word is taken from `mem_q_p1` in the cycle after the address cycle, and the second from `mem_q_p0` one cycle later. `rsp_valid` is 1 three cycles after the address cycle.
- R9: `rsp_rdata` is in address order. The word at the even address is in `[DW-1:0]` and the word at the odd address is in `[2*DW-1:DW]`, whatever the start address was.
- R10: Each read produces exactly one `rsp_valid` cycle, and responses come back in request order.
- R11: `mem_d_oe` is 0 in every cycle in which read data is due on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_off | input | 1 | Read timing mode, sampled with each request (1 = one-cycle return) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address; bit 0 selects the first word of the burst |
| req_wdata | input | 2*DW | Write pair in address order |
| req_be | input | 2*DW/9 | Active-high lane enables, word 0 lanes low |
| rsp_valid | output | 1 | Read pair valid for one cycle |
| rsp_rdata | output | 2*DW | Read pair in address order |
| mem_ld_n | output | 1 | Active-low access strobe |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Memory address |
| mem_bws_n_p0 | output | DW/9 | Active-low lane selects, first phase |
| mem_bws_n_p1 | output | DW/9 | Active-low lane selects, second phase |
| mem_d_oe | output | 1 | Data bus drive enable |
| mem_d_p0 | output | DW | Write word, first phase |
| mem_d_p1 | output | DW | Write word, second phase |
| mem_q_p0 | input | DW | Read data seen in the first phase |
| mem_q_p1 | input | DW | Read data seen in the second phase |

## Verification
The bench targets odd start addresses. A design that ignored the burst wrap would write the pair swapped, or return it swapped, and the scoreboard data would then mismatch. It switches the timing mode between back-to-back reads, so a design that picks the wrong phase or counts latency in the wrong mode returns junk words or asserts `rsp_valid` a cycle early or late. Reads are followed immediately by writes to expose a missing turnaround slot, which would show up as a short read-to-write gap or a driven bus while read data is due. Partial lane enables followed by readback catch inverted or misplaced byte write selects.

// File: rtl/burst2_sram_ctrl.sv
module burst2_sram_ctrl #(
  parameter int AW = 20,
  parameter int DW = 18,
  parameter int QD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_off,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic [2*DW/9-1:0] req_be,
  output logic              rsp_valid,
  output logic [2*DW-1:0]   rsp_rdata,
  output logic              mem_ld_n,
  output logic              mem_rw,
  output logic [AW-1:0]     mem_addr,
  output logic [DW/9-1:0]   mem_bws_n_p0,
  output logic [DW/9-1:0]   mem_bws_n_p1,
  output logic              mem_d_oe,
  output logic [DW-1:0]     mem_d_p0,
  output logic [DW-1:0]     mem_d_p1,
  input  logic [DW-1:0]     mem_q_p0,
  input  logic [DW-1:0]     mem_q_p1
);
  localparam int LN = DW / 9;
  localparam int QW = (QD > 1) ? $clog2(QD) : 1;

  logic acc, push, pop, busy, a_off, a_rd;
  logic rd1, rd1_off, rd2, done;
  logic [1:0] wr_hold;
  logic [QW:0] q_cnt;
  logic [QW-1:0] q_wp, q_rp;
  logic [QD-1:0] q_tag;
  logic wst_v;
  logic [DW-1:0] wst_d0, wst_d1, hold0, first_w, second_w;
  logic [LN-1:0] wst_b0, wst_b1;

  assign acc  = req_valid && req_ready;
  assign push = acc && !req_write;
  assign pop  = done;
  assign req_ready = !busy && (req_write ? (wr_hold == 2'd0) : (q_cnt != (QW+1)'(QD)));

  // address slot: one access every other cycle, turnaround after reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ld_n <= 1'b1;
      mem_rw   <= 1'b1;
      mem_addr <= '0;
      a_off    <= 1'b0;
      busy     <= 1'b0;
      wr_hold  <= 2'd0;
    end else begin
      mem_ld_n <= !acc;
      busy     <= acc;
      if (acc) begin
        mem_rw   <= !req_write;
        mem_addr <= req_addr;
        a_off    <= dll_off;
      end
      if (push) wr_hold <= 2'd3;
      else if (wr_hold != 2'd0) wr_hold <= wr_hold - 2'd1;
    end
  end

  // write pair, reordered so the addressed word leads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst_v        <= 1'b0;
      wst_d0       <= '0;
      wst_d1       <= '0;
      wst_b0       <= '0;
      wst_b1       <= '0;
      mem_d_oe     <= 1'b0;
      mem_d_p0     <= '0;
      mem_d_p1     <= '0;
      mem_bws_n_p0 <= '1;
      mem_bws_n_p1 <= '1;
    end else begin
      wst_v <= acc && req_write;
      if (acc && req_write) begin
        wst_d0 <= req_addr[0] ? req_wdata[2*DW-1:DW] : req_wdata[DW-1:0];
        wst_d1 <= req_addr[0] ? req_wdata[DW-1:0]    : req_wdata[2*DW-1:DW];
        wst_b0 <= req_addr[0] ? req_be[2*LN-1:LN]    : req_be[LN-1:0];
        wst_b1 <= req_addr[0] ? req_be[LN-1:0]       : req_be[2*LN-1:LN];
      end
      mem_d_oe     <= wst_v;
      mem_bws_n_p0 <= wst_v ? ~wst_b0 : '1;
      mem_bws_n_p1 <= wst_v ? ~wst_b1 : '1;
      if (wst_v) begin
        mem_d_p0 <= wst_d0;
        mem_d_p1 <= wst_d1;
      end
    end
  end

  // read return: phase pick depends on the mode latched with the address
  assign a_rd     = !mem_ld_n && mem_rw;
  assign done     = (rd1 && rd1_off) || rd2;
  assign first_w  = rd2 ? hold0    : mem_q_p0;
  assign second_w = rd2 ? mem_q_p0 : mem_q_p1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd1       <= 1'b0;
      rd1_off   <= 1'b0;
      rd2       <= 1'b0;
      hold0     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rd1     <= a_rd;
      rd1_off <= a_off;
      rd2     <= rd1 && !rd1_off;
      if (rd1 && !rd1_off) hold0 <= mem_q_p1;
      rsp_valid <= done;
      if (done) rsp_rdata <= q_tag[q_rp] ? {first_w, second_w} : {second_w, first_w};
    end
  end

  // in-order tag queue of outstanding reads (start-word bit)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_tag <= '0;
      q_wp  <= '0;
      q_rp  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) begin
        q_tag[q_wp] <= req_addr[0];
        q_wp <= (q_wp == QW'(QD-1)) ? '0 : q_wp + 1'b1;
      end
      if (pop) q_rp <= (q_rp == QW'(QD-1)) ? '0 : q_rp + 1'b1;
      q_cnt <= q_cnt + (QW+1)'(push) - (QW+1)'(pop);
    end
  end
endmodule

// File: rtl/burst2_sram_ctrl_chk.sv
module burst2_sram_ctrl_chk #(
  parameter int LN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_ld_n,
  input logic          mem_rw,
  input logic          mem_d_oe,
  input logic [LN-1:0] mem_bws_n_p0,
  input logic [LN-1:0] mem_bws_n_p1
);
  a_r1_idle_out_of_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_ld_n && !mem_d_oe));

  a_r3_addr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ld_n |=> mem_ld_n);

  a_r3_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_data_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && !mem_rw) |=> mem_d_oe);

  a_r4_drive_only_for_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_d_oe |-> $past(!mem_ld_n && !mem_rw));

  a_r5_selects_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_d_oe |-> ((&mem_bws_n_p0) && (&mem_bws_n_p1)));

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && mem_rw) |=> ##1 (mem_ld_n || mem_rw));

  a_r11_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ld_n && mem_rw) |=> !mem_d_oe ##1 !mem_d_oe);
endmodule

bind burst2_sram_ctrl burst2_sram_ctrl_chk #(.LN(DW/9)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_d_oe(mem_d_oe),
  .mem_bws_n_p0(mem_bws_n_p0), .mem_bws_n_p1(mem_bws_n_p1)
);

// File: tb/burst2_sram_ctrl_test.sv
module burst2_sram_ctrl_test;
  localparam int AW = 20;
  localparam int DW = 18;
  localparam int LN = DW / 9;
  localparam logic [DW-1:0] JUNK = DW'('h2A5A5);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic dll_off = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, rsp_valid, mem_ld_n, mem_rw, mem_d_oe;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [2*DW-1:0] req_wdata = '0, rsp_rdata;
  logic [2*LN-1:0] req_be = '0;
  logic [LN-1:0] mem_bws_n_p0, mem_bws_n_p1;
  logic [DW-1:0] mem_d_p0, mem_d_p1;
  logic [DW-1:0] mem_q_p0 = '0, mem_q_p1 = '0;

  burst2_sram_ctrl #(.AW(AW), .DW(DW), .QD(4)) uut (
    .clk(clk), .rst_n(rst_n), .dll_off(dll_off), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ld_n(mem_ld_n), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_bws_n_p0(mem_bws_n_p0), .mem_bws_n_p1(mem_bws_n_p1),
    .mem_d_oe(mem_d_oe), .mem_d_p0(mem_d_p0), .mem_d_p1(mem_d_p1),
    .mem_q_p0(mem_q_p0), .mem_q_p1(mem_q_p1));

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed { logic rw; logic [AW-1:0] a; logic off; int cy; } bus_t;
  typedef struct packed { logic [2*DW-1:0] d; logic off; int cy; } rsp_t;
  bus_t busq[$];
  rsp_t rspq[$];
  logic [DW-1:0] sh[int];
  logic [DW-1:0] mm[int];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] shr(input logic [AW-1:0] a);
    return sh.exists(int'(a)) ? sh[int'(a)] : '0;
  endfunction
  function automatic logic [DW-1:0] mmr(input logic [AW-1:0] a);
    return mm.exists(int'(a)) ? mm[int'(a)] : '0;
  endfunction

  // driver: computes expectations from the requirements and queues them
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [2*DW-1:0] d,
                       input logic [2*LN-1:0] be, input bit off);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; dll_off = off;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    t = cyc;
    busq.push_back('{rw: !wr, a: a, off: off, cy: t + 1});
    if (wr) begin
      for (int k = 0; k < 2; k++) begin
        logic [AW-1:0] wa;
        logic [DW-1:0] w;
        wa = {a[AW-1:1], k[0]};
        w = shr(wa);
        for (int j = 0; j < LN; j++)
          if (be[k*LN+j]) w[9*j +: 9] = d[k*DW + 9*j +: 9];
        sh[int'(wa)] = w;
      end
    end else begin
      rspq.push_back('{d: {shr({a[AW-1:1], 1'b1}), shr({a[AW-1:1], 1'b0})},
                       off: off, cy: t + (off ? 3 : 4)});
    end
    @(posedge clk);
    #1;
    chk(req_ready == 1'b0, "R3 ready after accept", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
  endtask

  // memory model and monitor
  logic r1_v = 1'b0, r1_off = 1'b0, r2_v = 1'b0, w1_v = 1'b0, prev_ld = 1'b0;
  logic [AW-1:0] r1_a = '0, r2_a = '0, w1_a = '0;
  int last_rd = -100;

  always @(negedge clk) begin
    if (rst_n) begin
      mem_q_p0 = JUNK;
      mem_q_p1 = ~JUNK;
      if (r1_v && r1_off) begin
        mem_q_p0 = mmr(r1_a);
        mem_q_p1 = mmr(r1_a ^ AW'(1));
      end else if (r1_v) mem_q_p1 = mmr(r1_a);
      if (r2_v) mem_q_p0 = mmr(r2_a ^ AW'(1));

      if (r1_v || r2_v) chk(!mem_d_oe, "R11 bus released", 64'(mem_d_oe), 64'd0);

      if (w1_v) begin
        logic [DW-1:0] w;
        chk(mem_d_oe, "R4 write data drive", 64'(mem_d_oe), 64'd1);
        w = mmr(w1_a);
        for (int j = 0; j < LN; j++) if (!mem_bws_n_p0[j]) w[9*j +: 9] = mem_d_p0[9*j +: 9];
        mm[int'(w1_a)] = w;
        w = mmr(w1_a ^ AW'(1));
        for (int j = 0; j < LN; j++) if (!mem_bws_n_p1[j]) w[9*j +: 9] = mem_d_p1[9*j +: 9];
        mm[int'(w1_a ^ AW'(1))] = w;
      end else begin
        if (mem_d_oe) chk(1'b0, "R4 stray drive", 64'(mem_d_oe), 64'd0);
        if (!(&mem_bws_n_p0 && &mem_bws_n_p1))
          chk(1'b0, "R5 idle selects", 64'({mem_bws_n_p1, mem_bws_n_p0}), 64'('1));
      end

      r2_v = r1_v && !r1_off;
      r2_a = r1_a;
      r1_v = 1'b0;
      w1_v = 1'b0;
      if (!mem_ld_n) begin
        chk(!prev_ld, "R3 address spacing", 64'(prev_ld), 64'd0);
        if (busq.size() == 0) chk(1'b0, "R2 unexpected access", 64'(mem_addr), 64'd0);
        else begin
          bus_t e;
          e = busq.pop_front();
          chk(mem_rw == e.rw && mem_addr == e.a, "R2 address/select",
              64'({mem_rw, mem_addr}), 64'({e.rw, e.a}));
          chk(cyc == e.cy, "R2 address cycle", 64'(cyc), 64'(e.cy));
          if (mem_rw) begin
            r1_v = 1'b1; r1_a = mem_addr; r1_off = e.off; last_rd = cyc;
          end else begin
            chk(cyc - last_rd >= 4, "R6 turnaround", 64'(cyc - last_rd), 64'd4);
            w1_v = 1'b1; w1_a = mem_addr;
          end
        end
      end
      prev_ld = !mem_ld_n;

      if (rsp_valid) begin
        if (rspq.size() == 0) chk(1'b0, "R10 extra response", 64'(rsp_rdata), 64'd0);
        else begin
          rsp_t e;
          e = rspq.pop_front();
          chk(rsp_rdata == e.d, "R9 read pair order", 64'(rsp_rdata), 64'(e.d));
          chk(cyc == e.cy, e.off ? "R7 one-cycle latency" : "R8 one-and-half latency",
              64'(cyc), 64'(e.cy));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    tests++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mem_ld_n && !mem_d_oe && !rsp_valid && (&mem_bws_n_p0) && (&mem_bws_n_p1),
        "R1 reset outputs", 64'({mem_ld_n, mem_d_oe, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    #1;
    chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'd1);

    // R4 R5: even and odd start, full and partial lanes
    issue(1'b1, AW'('h10), 36'h1_2345_6789, 4'b1111, 1'b0);
    issue(1'b1, AW'('h13), 36'hA_BCDE_F012, 4'b1111, 1'b0);
    issue(1'b1, AW'('h20), 36'h3_3333_3333, 4'b1111, 1'b0);
    issue(1'b1, AW'('h20), 36'hC_CCCC_CCCC, 4'b0110, 1'b0);
    issue(1'b1, AW'('h25), 36'h5_5555_5555, 4'b1111, 1'b0);
    issue(1'b1, AW'('h25), 36'hE_EEEE_EEEE, 4'b1001, 1'b0);
    // R7 R8 R9: both modes, both start words
    issue(1'b0, AW'('h10), '0, '0, 1'b0);
    issue(1'b0, AW'('h11), '0, '0, 1'b0);
    issue(1'b0, AW'('h12), '0, '0, 1'b1);
    issue(1'b0, AW'('h13), '0, '0, 1'b1);
    issue(1'b0, AW'('h20), '0, '0, 1'b0);
    issue(1'b0, AW'('h25), '0, '0, 1'b1);
    // R10: mixed-mode back-to-back reads; R6: read then write at once
    issue(1'b0, AW'('h21), '0, '0, 1'b0);
    issue(1'b0, AW'('h24), '0, '0, 1'b1);
    issue(1'b1, AW'('h30), 36'h7_0F0F_0F0F, 4'b1111, 1'b0);
    issue(1'b0, AW'('h31), '0, '0, 1'b1);
    issue(1'b1, AW'('h33), 36'h9_1111_2222, 4'b1011, 1'b1);
    issue(1'b0, AW'('h32), '0, '0, 1'b0);

    for (int i = 0; i < 80; i++) begin
      issue(1'($urandom_range(0, 1)), AW'(32 + $urandom_range(0, 15)),
            (2*DW)'({$urandom(), $urandom()}), (2*LN)'($urandom()), 1'($urandom_range(0, 1)));
    end

    repeat (10) @(negedge clk);
    chk(rspq.size() == 0, "R10 all reads answered", 64'(rspq.size()), 64'd0);
    chk(busq.size() == 0, "R2 all accesses issued", 64'(busq.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule